// File: doc/BRIEF.md
# System Clock Source Selector

This block chooses which of three sources drives the system clock: the on-chip RC oscillator, the external oscillator, or the PLL output. Software writes a two-bit request into the configuration word. The two-bit status field, which software can only read, follows the request only once the requested source reports ready. Until then the system keeps running from the previous source.

A control word holds the enables for the three sources and the external-bypass flag. The block refuses to clear an enable whose source currently feeds the system clock, whether that source feeds it directly or as the PLL reference. The PLL reference choice, the reference pre-divider and the multiply field are held in the configuration word and are frozen while the PLL is enabled. The effective multiply factor is driven on an output port. The oscillators and the PLL are outside the block; each one is seen only as an enable output and a ready input.

Top module: `sysclk_select`

## Requirements
- R1: Reset state: the RC oscillator is enabled, the other enables and the bypass flag are clear, the request and status fields are 0, all PLL fields are 0, and the factor output is 2.
- R2: A write with `wr_addr`=1 stores `wr_data[1:0]` as the request, with 0 = RC, 1 = external, 2 = PLL and 3 = reserved. Bits 3:2 of the same word are the status field, and a write to them has no effect.
- R3: The status takes the value of the stored request at the first rising edge where the ready input of that source is high. Until then it keeps its previous value. A request written at edge N can complete at edge N+1 at the earliest.
- R4: The reserved request value 3 never changes the status.
- R5: A write with `wr_addr`=0 that clears bit 0 (RC enable) is ignored for that bit while the status is 0, or while the status is 2 with PLL reference bit 16 = 0.
- R6: A write that clears bit 1 (external enable) is ignored for that bit while the status is 1, or while the status is 2 with reference bit 16 = 1. In the same condition a write to bit 2 (bypass) is ignored.
- R7: A write that clears bit 3 (PLL enable) is ignored while the status is 2.
- R8: Configuration bit 16 (reference: 0 = RC/2, 1 = external), bit 17 (pre-divide the external reference by 2) and bits 21:18 (multiply field) keep their value on any write while the PLL enable is set.
- R9: `pll_factor` equals the multiply field plus 2, saturated at 16. Field values 14 and 15 both give 16.
- R10: A control write always sets the enable and bypass bits written as 1, except bypass in the R6 case. `ctrl_rd` returns these bits at positions 0, 1, 2 and 3, and the enable outputs mirror them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control word, 1 = configuration word |
| wr_data | input | 32 | Write data |
| rc_rdy | input | 1 | RC oscillator ready |
| ext_rdy | input | 1 | External oscillator ready |
| pll_rdy | input | 1 | PLL locked |
| ctrl_rd | output | 32 | Control word readback |
| cfg_rd | output | 32 | Configuration word readback, including status |
| rc_en | output | 1 | RC oscillator enable |
| ext_en | output | 1 | External oscillator enable |
| ext_bypass | output | 1 | External input taken as a clock, not a crystal |
| pll_en | output | 1 | PLL enable |
| pll_ref_ext | output | 1 | PLL reference is the external oscillator |
| pll_ref_div2 | output | 1 | External PLL reference is divided by 2 |
| pll_factor | output | 5 | Effective PLL multiply factor |
| sys_src | output | 2 | Source currently driving the system clock |

## Verification
The bench holds a ready input low after a request so the status must stay on the old source. It then raises the ready input and expects the switch on the next edge; a design that copied the request at once would report a source that is not running. It tries to clear each enable while that source is active, including the RC and external oscillators when they serve only as the PLL reference, so a design that ignored the indirect path would stop the PLL's input. It also rewrites the PLL fields while the PLL is enabled, writes the reserved request value, and writes multiply field 15, where a missing saturation would report 17.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

   typedef enum logic [1:0] {
      SRC_RC  = 2'd0,
      SRC_EXT = 2'd1,
      SRC_PLL = 2'd2,
      SRC_RSV = 2'd3
   } src_e;

   // control word bit positions
   localparam int CB_RC  = 0;
   localparam int CB_EXT = 1;
   localparam int CB_BYP = 2;
   localparam int CB_PLL = 3;

   // configuration word positions (switch/status/PLL fields)
   localparam int SW_LSB   = 0;
   localparam int ST_LSB   = 2;
   localparam int REF_BIT  = 16;
   localparam int PDIV_BIT = 17;
   localparam int MUL_LSB  = 18;

endpackage

// File: rtl/sysclk_osc_ctrl.sv
module sysclk_osc_ctrl
   import sysclk_pkg::*;
#(
   parameter int         NSRC   = 3,
   parameter logic [2:0] RST_EN = 3'b001
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [3:0]      wdata,
   input  src_e            stat,
   input  logic            ref_ext,
   output logic [NSRC-1:0] en,
   output logic            byp
);

   logic [NSRC-1:0] lock;
   logic [NSRC-1:0] want;

   always_comb begin
      lock[0] = (stat == SRC_RC)  || ((stat == SRC_PLL) && !ref_ext);
      lock[1] = (stat == SRC_EXT) || ((stat == SRC_PLL) &&  ref_ext);
      lock[2] = (stat == SRC_PLL);
      want    = {wdata[CB_PLL], wdata[CB_EXT], wdata[CB_RC]};
   end

   for (genvar g = 0; g < NSRC; g++) begin : g_en
      always_ff @(posedge clk) begin
         if (!rst_n)  en[g] <= RST_EN[g];
         else if (wr) en[g] <= want[g] | (lock[g] & en[g]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)             byp <= 1'b0;
      else if (wr && !lock[1]) byp <= wdata[CB_BYP];
   end

   assert_rc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en[0]) |-> ($past(stat) != SRC_RC) &&
                       !(($past(stat) == SRC_PLL) && !$past(ref_ext)));

   assert_ext_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en[1]) |-> ($past(stat) != SRC_EXT) &&
                       !(($past(stat) == SRC_PLL) && $past(ref_ext)));

   assert_byp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat) == SRC_EXT) |-> $stable(byp));

   assert_pll_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en[2]) |-> ($past(stat) != SRC_PLL));

endmodule

// File: rtl/sysclk_pll_cfg.sv
module sysclk_pll_cfg #(
   parameter int MUL_W      = 4,
   parameter int MAX_FACTOR = 16,
   localparam int FACT_W    = $clog2(MAX_FACTOR + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              pll_on,
   input  logic              w_ref,
   input  logic              w_div,
   input  logic [MUL_W-1:0]  w_mul,
   output logic              ref_ext,
   output logic              ref_div2,
   output logic [MUL_W-1:0]  mul,
   output logic [FACT_W-1:0] factor
);

   localparam int SUM_W = (MUL_W + 1 > FACT_W) ? MUL_W + 1 : FACT_W;

   logic [SUM_W-1:0] sum;

   if (MAX_FACTOR < 2) begin : g_bad_max
      $error("MAX_FACTOR must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_ext  <= 1'b0;
         ref_div2 <= 1'b0;
         mul      <= '0;
      end else if (wr && !pll_on) begin
         ref_ext  <= w_ref;
         ref_div2 <= w_div;
         mul      <= w_mul;
      end
   end

   always_comb begin
      sum = SUM_W'(mul) + SUM_W'(2);
      if (sum > SUM_W'(MAX_FACTOR)) factor = FACT_W'(MAX_FACTOR);
      else                          factor = FACT_W'(sum);
   end

   assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pll_on) |-> $stable({ref_ext, ref_div2, mul}));

   assert_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (factor >= FACT_W'(2)) && (factor <= FACT_W'(MAX_FACTOR)));

endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
   import sysclk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [1:0] w_req,
   input  logic [2:0] rdy,
   output src_e       req,
   output src_e       stat
);

   logic [3:0] rdy_x;

   assign rdy_x = {1'b0, rdy};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req  <= SRC_RC;
         stat <= SRC_RC;
      end else begin
         if (wr) req <= src_e'(w_req);
         if ((req != SRC_RSV) && rdy_x[req]) stat <= req;
      end
   end

   assert_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat != $past(stat)) |-> ((stat == $past(req)) && $past(rdy_x[req])));

   assert_no_rsv_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stat != SRC_RSV);

endmodule

// File: rtl/sysclk_select.sv
module sysclk_select
   import sysclk_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int MUL_W      = 4,
   parameter int MAX_FACTOR = 16,
   localparam int FACT_W    = $clog2(MAX_FACTOR + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rc_rdy,
   input  logic              ext_rdy,
   input  logic              pll_rdy,
   output logic [DATA_W-1:0] ctrl_rd,
   output logic [DATA_W-1:0] cfg_rd,
   output logic              rc_en,
   output logic              ext_en,
   output logic              ext_bypass,
   output logic              pll_en,
   output logic              pll_ref_ext,
   output logic              pll_ref_div2,
   output logic [FACT_W-1:0] pll_factor,
   output src_e              sys_src
);

   if (DATA_W < MUL_LSB + MUL_W) begin : g_bad_width
      $error("DATA_W too narrow for the configuration fields");
   end

   logic       wr_ctrl, wr_cfg;
   logic [2:0] en;
   logic [MUL_W-1:0] mul;
   src_e       req;

   assign wr_ctrl = wr_en && !wr_addr;
   assign wr_cfg  = wr_en &&  wr_addr;

   sysclk_switch i_switch (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_cfg),
      .w_req (wr_data[SW_LSB +: 2]),
      .rdy   ({pll_rdy, ext_rdy, rc_rdy}),
      .req   (req),
      .stat  (sys_src)
   );

   sysclk_osc_ctrl i_osc (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_ctrl),
      .wdata   (wr_data[3:0]),
      .stat    (sys_src),
      .ref_ext (pll_ref_ext),
      .en      (en),
      .byp     (ext_bypass)
   );

   sysclk_pll_cfg #(.MUL_W(MUL_W), .MAX_FACTOR(MAX_FACTOR)) i_pll (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_cfg),
      .pll_on   (en[2]),
      .w_ref    (wr_data[REF_BIT]),
      .w_div    (wr_data[PDIV_BIT]),
      .w_mul    (wr_data[MUL_LSB +: MUL_W]),
      .ref_ext  (pll_ref_ext),
      .ref_div2 (pll_ref_div2),
      .mul      (mul),
      .factor   (pll_factor)
   );

   assign rc_en  = en[0];
   assign ext_en = en[1];
   assign pll_en = en[2];

   always_comb begin
      ctrl_rd         = '0;
      ctrl_rd[CB_RC]  = en[0];
      ctrl_rd[CB_EXT] = en[1];
      ctrl_rd[CB_BYP] = ext_bypass;
      ctrl_rd[CB_PLL] = en[2];
      cfg_rd                     = '0;
      cfg_rd[SW_LSB +: 2]        = req;
      cfg_rd[ST_LSB +: 2]        = sys_src;
      cfg_rd[REF_BIT]            = pll_ref_ext;
      cfg_rd[PDIV_BIT]           = pll_ref_div2;
      cfg_rd[MUL_LSB +: MUL_W]   = mul;
   end

endmodule

// File: tb/test_sysclk_select.sv
module test_sysclk_select;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_addr = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rc_rdy = 1'b1, ext_rdy = 1'b0, pll_rdy = 1'b0;
   logic [31:0] ctrl_rd, cfg_rd;
   logic        rc_en, ext_en, ext_bypass, pll_en, pll_ref_ext, pll_ref_div2;
   logic [4:0]  pll_factor;
   logic [1:0]  sys_src;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   sysclk_select i_sysclk_select (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rc_rdy(rc_rdy), .ext_rdy(ext_rdy), .pll_rdy(pll_rdy),
      .ctrl_rd(ctrl_rd), .cfg_rd(cfg_rd), .rc_en(rc_en), .ext_en(ext_en),
      .ext_bypass(ext_bypass), .pll_en(pll_en), .pll_ref_ext(pll_ref_ext),
      .pll_ref_div2(pll_ref_div2), .pll_factor(pll_factor), .sys_src(sys_src)
   );

   // behavioural reference model
   int m_rc, m_ext, m_byp, m_pll, m_req, m_st, m_ref, m_div, m_mul;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rc = 1; m_ext = 0; m_byp = 0; m_pll = 0;
         m_req = 0; m_st = 0; m_ref = 0; m_div = 0; m_mul = 0;
      end else begin
         automatic bit busy_rc  = (m_st == 0) || (m_st == 2 && m_ref == 0);
         automatic bit busy_ext = (m_st == 1) || (m_st == 2 && m_ref == 1);
         automatic bit busy_pll = (m_st == 2);
         automatic int nxt_st = m_st;
         automatic bit r_ok = (m_req == 0 && rc_rdy) || (m_req == 1 && ext_rdy) ||
                              (m_req == 2 && pll_rdy);
         if (r_ok) nxt_st = m_req;
         if (wr_en && !wr_addr) begin
            m_rc  = (wr_data[0] || (busy_rc  && m_rc  != 0)) ? 1 : 0;
            m_ext = (wr_data[1] || (busy_ext && m_ext != 0)) ? 1 : 0;
            m_pll = (wr_data[3] || (busy_pll && m_pll != 0)) ? 1 : 0;
            if (!busy_ext) m_byp = wr_data[2];
         end
         if (wr_en && wr_addr) begin
            m_req = wr_data[1:0];
            if (m_pll == 0) begin
               m_ref = wr_data[16]; m_div = wr_data[17]; m_mul = wr_data[21:18];
            end
         end
         m_st = nxt_st;
      end
   end

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // compare on every falling edge
   always @(negedge clk) begin
      if (!done) begin
         automatic string rt = rst_n ? "" : "R1 ";
         chk({rt, "R3"}, "sys_src", sys_src, m_st);
         chk({rt, "R2"}, "request field", cfg_rd[1:0], m_req);
         chk({rt, "R2"}, "status field", cfg_rd[3:2], m_st);
         chk({rt, "R5"}, "rc_en", rc_en, m_rc);
         chk({rt, "R6"}, "ext_en", ext_en, m_ext);
         chk({rt, "R6"}, "ext_bypass", ext_bypass, m_byp);
         chk({rt, "R7"}, "pll_en", pll_en, m_pll);
         chk({rt, "R8"}, "pll fields", {pll_ref_ext, pll_ref_div2, cfg_rd[21:18]},
             {m_ref[0], m_div[0], m_mul[3:0]});
         chk({rt, "R9"}, "pll_factor", pll_factor, (m_mul + 2 > 16) ? 16 : m_mul + 2);
         chk({rt, "R10"}, "ctrl_rd", ctrl_rd, m_rc | (m_ext << 1) | (m_byp << 2) | (m_pll << 3));
      end
   end

   task automatic wr(bit a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] cfgw(int rq, int rf, int dv, int ml);
      return (32'(ml) << 18) | (32'(dv) << 17) | (32'(rf) << 16) | 32'(rq);
   endfunction

   task automatic finish_run();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      idle(3);
      chk("R1", "factor after reset", pll_factor, 2);
      chk("R1", "ctrl_rd after reset", ctrl_rd, 1);
      rst_n = 1'b1;
      idle(2);
      // R5: cannot stop RC while it is the source
      wr(0, 32'h0);
      chk("R5", "rc_en kept", rc_en, 1);
      // R3: switch to external waits for ready
      wr(0, 32'h3);
      wr(1, cfgw(1, 0, 0, 0));
      idle(4);
      chk("R3", "status waits", sys_src, 0);
      ext_rdy = 1'b1;
      idle(2);
      chk("R3", "status switched", sys_src, 1);
      // R6: external locked, bypass locked; RC may stop
      wr(0, 32'h0);
      chk("R6", "ext_en kept", ext_en, 1);
      chk("R5", "rc_en released", rc_en, 0);
      wr(0, 32'h6);
      chk("R6", "bypass ignored", ext_bypass, 0);
      // R8/R9: PLL from external /2, field 7 -> 9
      wr(1, cfgw(1, 1, 1, 7) | 32'hC);
      chk("R9", "factor 9", pll_factor, 9);
      chk("R2", "status not writable", sys_src, 1);
      wr(0, 32'hA);
      wr(1, cfgw(2, 0, 0, 3));
      chk("R8", "mult frozen", cfg_rd[21:18], 7);
      chk("R8", "ref frozen", pll_ref_ext, 1);
      idle(3);
      chk("R3", "pll not ready", sys_src, 1);
      pll_rdy = 1'b1;
      idle(2);
      chk("R3", "on pll", sys_src, 2);
      // R6/R7: via-PLL locks
      wr(0, 32'h1);
      chk("R7", "pll_en kept", pll_en, 1);
      chk("R6", "ext kept as pll ref", ext_en, 1);
      // R4 reserved request
      wr(1, cfgw(3, 0, 0, 0));
      idle(3);
      chk("R4", "reserved ignored", sys_src, 2);
      wr(1, cfgw(0, 0, 0, 0));
      idle(2);
      chk("R3", "back to rc", sys_src, 0);
      wr(0, 32'h1);
      chk("R7", "pll released", pll_en, 0);
      // R9 saturation
      wr(1, cfgw(0, 0, 0, 14));
      chk("R9", "factor field 14", pll_factor, 16);
      wr(1, cfgw(0, 0, 0, 15));
      chk("R9", "factor field 15", pll_factor, 16);
      // PLL from RC/2: RC locked through PLL
      wr(0, 32'h9);
      wr(1, cfgw(2, 0, 0, 15));
      idle(2);
      wr(0, 32'h8);
      chk("R5", "rc kept as pll ref", rc_en, 1);
      // random phase
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         rc_rdy = $urandom_range(0, 1); ext_rdy = $urandom_range(0, 1);
         pll_rdy = $urandom_range(0, 1);
         wr_en = ($urandom_range(0, 2) == 0);
         wr_addr = $urandom_range(0, 1);
         wr_data = $urandom;
      end
      @(negedge clk);
      wr_en = 1'b0;
      idle(2);
      finish_run();
   end

endmodule